// File: doc/BRIEF.md
# Legacy Parallel Bus Cycle Controller

This block masters a slow, legacy-style parallel bus on behalf of local logic. A local client presents one request at a time: an address, write data, a read/write flag and a flag that picks memory space or I/O space. The controller turns the request into a bus cycle. That cycle drives the address, and for writes the data, and then pulses the one active-low strobe, out of four, that matches the space and the direction. A read returns the captured bus data with a one-clock response.

A bus cycle with a ready target takes four clocks: address phase, two strobe clocks and a release clock. A slow target can pull the ready input low to stretch the strobe phase with wait clocks. The number of wait clocks has a hard limit. When the limit is reached the cycle finishes anyway and a sticky timeout flag is set. Memory cycles put out the full 20-bit address. I/O cycles put out a 16-bit address with the upper address lines held at zero.

The request side is valid/ready. A request transfers on a clock where both `req_valid` and `req_ready` are high. `req_ready` is high only while the controller is idle, so a client holding `req_valid` simply waits. The response side has no back-pressure. `rsp_valid` is a single-clock pulse, and the client must take `rsp_rdata` on that clock. `timeout` is a plain status pin.

Top module: `legacy_bus_master`

## Requirements
- R1: `req_ready` is high only while no bus cycle is in progress. A request is accepted only on a clock edge where `req_valid` and `req_ready` are both high. A `req_valid` held high during a cycle starts nothing until the controller is idle again, so with a ready target a held request completes once every 5 clocks.
- R2: With the ready input high, the cycle lasts four clocks after acceptance. In clock 1 the address is out and all strobes are high. In clocks 2 and 3 the selected strobe is low. In clock 4 all strobes are high again.
- R3: `bus_addr` carries all 20 request address bits for memory cycles. For I/O cycles it carries the low 16 bits, with bits 19:16 at zero. It holds the same value from clock 1 through the last clock of the cycle, and it is zero when idle.
- R4: Exactly one strobe is low during the strobe phase. The strobe is `bus_memr_n` for a memory read, `bus_memw_n` for a memory write, `bus_ior_n` for an I/O read and `bus_iow_n` for an I/O write. Here `req_write`=1 means write and `req_io`=1 means I/O space.
- R5: `bus_ready` is sampled at the end of the second strobe clock and at the end of each wait clock. While it is sampled low, one more wait clock is inserted with the strobe held low.
- R6: At most MAX_WAIT (6) wait clocks are inserted. If `bus_ready` is still low at the end of the last allowed wait clock, the cycle completes and `timeout` goes high. `timeout` then stays high until reset. When `bus_ready` returns high exactly at the end of that last wait clock, `timeout` is not set.
- R7: Read data is taken from `bus_data_in` at the end of the last strobe clock. It is presented on `rsp_rdata` during the clock after the strobe phase, in which `rsp_valid` is high.
- R8: For writes, `bus_data_oe` is high and `bus_data_out` carries the write data from clock 1 until the end of the cycle. For reads, `bus_data_oe` stays low.
- R9: `rsp_valid` is high for exactly one clock per accepted request: the final (release) clock of its cycle.
- R10: While reset is asserted (asynchronous, active low), all strobes are high. `bus_data_oe`, `rsp_valid`, `timeout` and `bus_addr` are zero, and `req_ready` is high. A reset in the middle of a cycle ends the cycle at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can transfer |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_addr | input | ADDR_W (20) | Request address |
| req_wdata | input | DATA_W (8) | Write data |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_rdata | output | DATA_W (8) | Captured read data |
| timeout | output | 1 | Sticky wait-limit flag |
| bus_addr | output | ADDR_W (20) | Bus address lines |
| bus_data_out | output | DATA_W (8) | Bus data driven by the controller |
| bus_data_in | input | DATA_W (8) | Bus data driven by the target |
| bus_data_oe | output | 1 | Data output enable (writes only) |
| bus_memr_n | output | 1 | Memory read strobe, active low |
| bus_memw_n | output | 1 | Memory write strobe, active low |
| bus_ior_n | output | 1 | I/O read strobe, active low |
| bus_iow_n | output | 1 | I/O write strobe, active low |
| bus_ready | input | 1 | Target ready; low stretches the strobe |

## Verification
The wait limit and the target's ready can fall on the same clock edge: the sixth wait clock ends just as `bus_ready` returns high. The bench provokes this with a target that holds ready low for exactly six samples. It expects normal completion with no timeout. It then runs a target that holds ready low for seven samples, and expects a forced completion with `timeout` set. In both runs the target changes its data every strobe clock and puts the true value only on the final one, so the bench can tell whether capture happened at the right edge.

// File: rtl/lbm_pkg.sv
package lbm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_STB1,
    ST_STB2,
    ST_WAIT,
    ST_DONE
  } cyc_state_t;
endpackage

// File: rtl/lbm_sequencer.sv
module lbm_sequencer
  import lbm_pkg::*;
#(
  parameter int MAX_WAIT = 6,
  localparam int CNT_W = $clog2(MAX_WAIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_fire,
  input  logic bus_ready,
  output logic idle,
  output logic busy,
  output logic strobe_on,
  output logic capture,
  output logic done,
  output logic timeout
);

  cyc_state_t state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic to_q;
  logic at_limit;

  assign at_limit = (state_q == ST_WAIT) && (cnt_q == CNT_W'(MAX_WAIT));

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      ST_IDLE: if (req_fire) state_d = ST_ADDR;
      ST_ADDR: state_d = ST_STB1;
      ST_STB1: state_d = ST_STB2;
      ST_STB2: begin
        if (bus_ready) begin
          state_d = ST_DONE;
        end else begin
          state_d = ST_WAIT;
          cnt_d   = CNT_W'(1);
        end
      end
      ST_WAIT: begin
        if (bus_ready || at_limit) state_d = ST_DONE;
        else cnt_d = cnt_q + CNT_W'(1);
      end
      ST_DONE: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      to_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (at_limit && !bus_ready) to_q <= 1'b1;
    end
  end

  assign idle      = (state_q == ST_IDLE);
  assign busy      = !idle;
  assign strobe_on = (state_q == ST_STB1) || (state_q == ST_STB2) || (state_q == ST_WAIT);
  assign capture   = ((state_q == ST_STB2) && bus_ready) ||
                     ((state_q == ST_WAIT) && (bus_ready || at_limit));
  assign done      = (state_q == ST_DONE);
  assign timeout   = to_q;

  // R6: the wait counter never passes the limit
  assert_wait_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(MAX_WAIT));

  // R6: timeout flag is sticky
  assert_timeout_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    to_q |=> to_q);

  // R2: address clock is always followed by a strobe clock
  assert_addr_then_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ADDR) |=> strobe_on);

  // R5: a low ready at the end of a strobe clock keeps the strobe on
  assert_ready_low_stretch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_STB2) && !bus_ready) |=> strobe_on);

endmodule

// File: rtl/lbm_datapath.sv
module lbm_datapath #(
  parameter int ADDR_W    = 20,
  parameter int IO_ADDR_W = 16,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              capture,
  input  logic              busy,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_write,
  input  logic              req_io,
  input  logic [DATA_W-1:0] bus_data_in,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_data_out,
  output logic              bus_data_oe,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              write_q,
  output logic              io_q
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic [ADDR_W-1:0] io_mask;

  generate
    if (IO_ADDR_W < ADDR_W) begin : g_io_narrow
      assign io_mask = {{(ADDR_W - IO_ADDR_W){1'b0}}, {IO_ADDR_W{1'b1}}};
    end else begin : g_io_full
      assign io_mask = {ADDR_W{1'b1}};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
      io_q    <= 1'b0;
    end else if (load) begin
      addr_q  <= req_io ? (req_addr & io_mask) : req_addr;
      wdata_q <= req_wdata;
      write_q <= req_write;
      io_q    <= req_io;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else if (capture) rdata_q <= bus_data_in;
  end

  assign bus_addr     = busy ? addr_q : '0;
  assign bus_data_oe  = busy && write_q;
  assign bus_data_out = bus_data_oe ? wdata_q : '0;
  assign rsp_rdata    = rdata_q;

  // R3: address stays put for the whole cycle
  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(bus_addr));

endmodule

// File: rtl/lbm_strobe_gen.sv
module lbm_strobe_gen (
  input  logic strobe_on,
  input  logic write_q,
  input  logic io_q,
  output logic memr_n,
  output logic memw_n,
  output logic ior_n,
  output logic iow_n
);

  always_comb begin
    memr_n = 1'b1;
    memw_n = 1'b1;
    ior_n  = 1'b1;
    iow_n  = 1'b1;
    if (strobe_on) begin
      case ({io_q, write_q})
        2'b00: memr_n = 1'b0;
        2'b01: memw_n = 1'b0;
        2'b10: ior_n  = 1'b0;
        default: iow_n = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/legacy_bus_master.sv
module legacy_bus_master #(
  parameter int ADDR_W    = 20,
  parameter int IO_ADDR_W = 16,
  parameter int DATA_W    = 8,
  parameter int MAX_WAIT  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_io,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              timeout,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_data_out,
  input  logic [DATA_W-1:0] bus_data_in,
  output logic              bus_data_oe,
  output logic              bus_memr_n,
  output logic              bus_memw_n,
  output logic              bus_ior_n,
  output logic              bus_iow_n,
  input  logic              bus_ready
);

  logic idle, busy, strobe_on, capture, done;
  logic write_q, io_q;
  logic req_fire;

  assign req_fire  = req_valid && idle;
  assign req_ready = idle;
  assign rsp_valid = done;

  lbm_sequencer #(.MAX_WAIT(MAX_WAIT)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_fire  (req_fire),
    .bus_ready (bus_ready),
    .idle      (idle),
    .busy      (busy),
    .strobe_on (strobe_on),
    .capture   (capture),
    .done      (done),
    .timeout   (timeout)
  );

  lbm_datapath #(
    .ADDR_W    (ADDR_W),
    .IO_ADDR_W (IO_ADDR_W),
    .DATA_W    (DATA_W)
  ) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (req_fire),
    .capture      (capture),
    .busy         (busy),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .req_write    (req_write),
    .req_io       (req_io),
    .bus_data_in  (bus_data_in),
    .bus_addr     (bus_addr),
    .bus_data_out (bus_data_out),
    .bus_data_oe  (bus_data_oe),
    .rsp_rdata    (rsp_rdata),
    .write_q      (write_q),
    .io_q         (io_q)
  );

  lbm_strobe_gen u_stb (
    .strobe_on (strobe_on),
    .write_q   (write_q),
    .io_q      (io_q),
    .memr_n    (bus_memr_n),
    .memw_n    (bus_memw_n),
    .ior_n     (bus_ior_n),
    .iow_n     (bus_iow_n)
  );

  // R1: idle controller drives no strobe and no data
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (bus_memr_n && bus_memw_n && bus_ior_n && bus_iow_n && !bus_data_oe));

  // R9: completion pulse lasts a single clock
  assert_ack_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R8: data enable never overlaps a read strobe
  assert_oe_not_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_data_oe |-> (bus_memr_n && bus_ior_n));

  // R2: strobes are released in the completion clock
  assert_release_on_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (bus_memr_n && bus_memw_n && bus_ior_n && bus_iow_n));

  // R4: never more than one strobe low
  assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~bus_memr_n, ~bus_memw_n, ~bus_ior_n, ~bus_iow_n}) <= 1);

endmodule

// File: tb/tb_legacy_bus_master.sv
module tb_legacy_bus_master;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic        req_io = 1'b0;
  logic [19:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic        timeout;
  logic [19:0] bus_addr;
  logic [7:0]  bus_data_out;
  logic [7:0]  bus_data_in = '0;
  logic        bus_data_oe;
  logic        bus_memr_n, bus_memw_n, bus_ior_n, bus_iow_n;
  logic        bus_ready = 1'b1;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit exp_to = 0;

  always #5 clk = ~clk;

  legacy_bus_master dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_io(req_io), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .timeout(timeout),
    .bus_addr(bus_addr), .bus_data_out(bus_data_out), .bus_data_in(bus_data_in),
    .bus_data_oe(bus_data_oe), .bus_memr_n(bus_memr_n), .bus_memw_n(bus_memw_n),
    .bus_ior_n(bus_ior_n), .bus_iow_n(bus_iow_n), .bus_ready(bus_ready)
  );

  // vector: {write, io, addr[19:0], wdata[7:0], rdata[7:0], nwait[3:0]}
  localparam int NVEC = 9;
  localparam logic [41:0] VECS [0:NVEC-1] = '{
    {1'b0, 1'b0, 20'hA5F31, 8'h00, 8'h3C, 4'd0},
    {1'b1, 1'b0, 20'h0F00D, 8'h5A, 8'h00, 4'd0},
    {1'b0, 1'b1, 20'hF1234, 8'h00, 8'hC3, 4'd0},
    {1'b1, 1'b1, 20'h9ABCD, 8'hE7, 8'h00, 4'd1},
    {1'b0, 1'b0, 20'h12345, 8'h00, 8'h81, 4'd3},
    {1'b1, 1'b0, 20'hFFFFF, 8'h11, 8'h00, 4'd2},
    {1'b0, 1'b1, 20'h70002, 8'h00, 8'h6E, 4'd6},
    {1'b0, 1'b0, 20'h00001, 8'h00, 8'h99, 4'd7},
    {1'b1, 1'b1, 20'h3FFFF, 8'hA0, 8'h00, 4'd0}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_strobes(input bit on, input bit wr, input bit io);
    logic [3:0] s;
    s = 4'b1111;  // {memr_n, memw_n, ior_n, iow_n}
    if (on) s[3 - {io, wr}] = 1'b0;
    return s;
  endfunction

  task automatic run_txn(input bit wr, input bit io, input logic [19:0] addr,
                         input logic [7:0] wd, input logic [7:0] rd, input int nwait);
    logic [19:0] ea;
    int nstb;
    ea   = io ? {4'h0, addr[15:0]} : addr;
    nstb = 2 + ((nwait > 6) ? 6 : nwait);
    @(negedge clk);
    req_write = wr; req_io = io; req_addr = addr; req_wdata = wd;
    req_valid = 1'b1; bus_ready = 1'b1;
    chk(req_ready == 1'b1, "R1", "ready when idle", 32'(req_ready), 1);
    @(negedge clk);  // address clock
    req_valid = 1'b0;
    chk(bus_addr == ea, "R3", "address in clock 1", 32'(bus_addr), 32'(ea));
    chk({bus_memr_n, bus_memw_n, bus_ior_n, bus_iow_n} == 4'hF, "R2", "no strobe in clock 1",
        32'({bus_memr_n, bus_memw_n, bus_ior_n, bus_iow_n}), 32'hF);
    chk(bus_data_oe == wr, "R8", "oe in clock 1", 32'(bus_data_oe), 32'(wr));
    if (wr) chk(bus_data_out == wd, "R8", "write data in clock 1", 32'(bus_data_out), 32'(wd));
    chk(req_ready == 1'b0, "R1", "busy not ready", 32'(req_ready), 0);
    for (int s = 0; s < nstb; s++) begin
      @(negedge clk);
      chk({bus_memr_n, bus_memw_n, bus_ior_n, bus_iow_n} == exp_strobes(1'b1, wr, io),
          (s < 2) ? "R4" : "R5", "strobe pattern",
          32'({bus_memr_n, bus_memw_n, bus_ior_n, bus_iow_n}), 32'(exp_strobes(1'b1, wr, io)));
      chk(bus_addr == ea, "R3", "address held", 32'(bus_addr), 32'(ea));
      chk(rsp_valid == 1'b0, "R9", "no ack in strobe", 32'(rsp_valid), 0);
      if (wr) chk(bus_data_oe && bus_data_out == wd, "R8", "write data held",
                  32'(bus_data_out), 32'(wd));
      else chk(bus_data_oe == 1'b0, "R8", "oe low on read", 32'(bus_data_oe), 0);
      bus_ready   = (s == 0) ? 1'b1 : ((s - 1) >= nwait);
      bus_data_in = (s == nstb - 1) ? rd : ~rd;
    end
    @(negedge clk);  // release clock
    if (nwait > 6) exp_to = 1'b1;
    chk({bus_memr_n, bus_memw_n, bus_ior_n, bus_iow_n} == 4'hF, "R2", "strobes released",
        32'({bus_memr_n, bus_memw_n, bus_ior_n, bus_iow_n}), 32'hF);
    chk(rsp_valid == 1'b1, "R9", "ack in release clock", 32'(rsp_valid), 1);
    if (!wr) chk(rsp_rdata == rd, "R7", "read data capture", 32'(rsp_rdata), 32'(rd));
    chk(bus_addr == ea, "R3", "address in release clock", 32'(bus_addr), 32'(ea));
    chk(bus_data_oe == wr, "R8", "oe in release clock", 32'(bus_data_oe), 32'(wr));
    chk(timeout == exp_to, "R6", "timeout flag", 32'(timeout), 32'(exp_to));
    bus_ready = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R9", "ack single clock", 32'(rsp_valid), 0);
    chk(req_ready == 1'b1, "R1", "ready after cycle", 32'(req_ready), 1);
    chk(bus_addr == 20'h0, "R3", "address zero when idle", 32'(bus_addr), 0);
  endtask

  initial begin
    #(10 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk({bus_memr_n, bus_memw_n, bus_ior_n, bus_iow_n} == 4'hF, "R10", "strobes in reset",
        32'({bus_memr_n, bus_memw_n, bus_ior_n, bus_iow_n}), 32'hF);
    chk(!bus_data_oe && !rsp_valid && !timeout && bus_addr == 0, "R10", "outputs in reset",
        32'({bus_data_oe, rsp_valid, timeout}), 0);
    chk(req_ready == 1'b1, "R10", "ready in reset", 32'(req_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      logic [41:0] v;
      v = VECS[i];
      run_txn(v[41], v[40], v[39:20], v[19:12], v[11:4], int'(v[3:0]));
    end

    // R1: held request is taken once per 5 clocks, never during a cycle
    begin
      int acks;
      acks = 0;
      @(negedge clk);
      req_write = 1'b0; req_io = 1'b0; req_addr = 20'h00100; bus_ready = 1'b1;
      req_valid = 1'b1;
      for (int c = 0; c < 20; c++) begin
        @(negedge clk);
        if (rsp_valid) acks++;
      end
      req_valid = 1'b0;
      chk(acks == 4, "R1", "acks for held request", 32'(acks), 4);
      repeat (6) @(negedge clk);
      chk(req_ready == 1'b1, "R1", "idle after held request", 32'(req_ready), 1);
    end

    // R10: reset in mid-cycle releases strobes and clears sticky timeout
    @(negedge clk);
    req_write = 1'b1; req_io = 1'b0; req_addr = 20'h55555; req_wdata = 8'h77;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk(bus_memw_n == 1'b0, "R4", "write strobe before reset", 32'(bus_memw_n), 0);
    rst_n = 1'b0;
    #1;
    chk({bus_memr_n, bus_memw_n, bus_ior_n, bus_iow_n} == 4'hF && !bus_data_oe, "R10",
        "reset mid-cycle", 32'({bus_memr_n, bus_memw_n, bus_ior_n, bus_iow_n}), 32'hF);
    chk(timeout == 1'b0, "R10", "timeout cleared by reset", 32'(timeout), 0);
    @(negedge clk);
    rst_n = 1'b1;
    exp_to = 1'b0;
    run_txn(1'b0, 1'b1, 20'h0ABCD, 8'h00, 8'h42, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule